// File: doc/BRIEF.md
# Divide-by-2-or-3 Prescaler

This block divides an input clock by two or by three, with the ratio chosen by a single modulus-select input. It is the first cell of a dual-modulus divider chain: a counter running on the divided clock raises the select for one output period whenever it needs a pulse swallowed, which stretches that period to three input cycles.

Two registers make up the cell. A toggle register inverts itself on every input edge and drives the divided output. A hold register is loaded each edge with "select high and output low". When it is set, the toggle register keeps its value for one extra edge. The stall always lands in a high phase of the output, so a divide-by-3 period is two input cycles high and one low. The hold signal is also brought out, so that the chain above can see when a swallow is under way.

Top module: `dual_mod_prescaler`

## Requirements
- R1: With `rst` high at a rising edge, `div_out` and `hold_out` are both 0 after that edge.
- R2: At a rising edge where `hold_out` is 0, `div_out` takes the inverse of its present value.
- R3: At a rising edge where `hold_out` is 1, `div_out` keeps its present value.
- R4: At every rising edge out of reset, `hold_out` is loaded with `mod_sel` AND NOT `div_out`, both sampled at that edge.
- R5: With `mod_sel` held at 0, `div_out` alternates every input cycle: a period of 2 input cycles at 50% duty, and `hold_out` stays 0.
- R6: With `mod_sel` held at 1 from reset, `div_out` repeats the pattern 1,1,0 (period 3, high for two cycles) and `hold_out` repeats 1,0,0.
- R7: From the reset state, `mod_sel` high for exactly three edges and then low gives one output period of three input cycles (one pulse swallowed), and then the output returns to period 2.
- R8: A one-edge `mod_sel` pulse while `div_out` is 1 has no effect: `hold_out` stays 0 and `div_out` keeps alternating.
- R9: `hold_out` is never 1 while `div_out` is 0, and it is never 1 on two edges in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| mod_sel | input | 1 | Modulus select: 0 divides by 2, 1 divides by 3 |
| div_out | output | 1 | Divided clock (toggle register) |
| hold_out | output | 1 | Stall flag: output held for the coming edge |

## Verification
The assertions assume that `mod_sel` is a synchronous level that changes only between rising edges of `clk`. They make no assumption about how long `mod_sel` stays high, because the cell's reaction to any select pattern is defined edge by edge. The bench changes `mod_sel` one time unit after a rising edge, and every scenario begins from a reset, so the expected output sequences can be worked out by hand from R2 to R4. Held-high selects, a three-edge pulse and a one-edge pulse in the high phase cover both cases of the hold decision.

// File: rtl/dual_mod_prescaler_pkg.sv
package dual_mod_prescaler_pkg;

    typedef struct packed {
        logic level;
        logic hold;
    } presc_state_t;

    localparam presc_state_t PRESC_RESET = '{level: 1'b0, hold: 1'b0};

    function automatic logic toggle_next(input logic level, input logic hold);
        return hold ? level : ~level;
    endfunction

    function automatic logic hold_next(input logic sel, input logic level);
        return sel & ~level;
    endfunction

endpackage

// File: rtl/presc_hold_gate.sv
module presc_hold_gate
    import dual_mod_prescaler_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic level,
    output logic hold
);
    always_ff @(posedge clk) begin
        if (rst) hold <= PRESC_RESET.hold;
        else     hold <= hold_next(sel, level);
    end
endmodule

// File: rtl/presc_toggle_stage.sv
module presc_toggle_stage
    import dual_mod_prescaler_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic level
);
    always_ff @(posedge clk) begin
        if (rst) level <= PRESC_RESET.level;
        else     level <= toggle_next(level, hold);
    end
endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler
    import dual_mod_prescaler_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mod_sel,
    output logic div_out,
    output logic hold_out
);
    presc_state_t st;

    presc_toggle_stage u_toggle (
        .clk  (clk),
        .rst  (rst),
        .hold (st.hold),
        .level(st.level)
    );

    presc_hold_gate u_gate (
        .clk  (clk),
        .rst  (rst),
        .sel  (mod_sel),
        .level(st.level),
        .hold (st.hold)
    );

    assign div_out  = st.level;
    assign hold_out = st.hold;
endmodule

// File: rtl/dual_mod_prescaler_checker.sv
module dual_mod_prescaler_checker (
    input logic clk,
    input logic rst,
    input logic mod_sel,
    input logic div_out,
    input logic hold_out
);
    // R1: reset clears both registers
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!div_out && !hold_out));

    // R2: no hold means the output flips
    a_r2_toggle: assert property (@(posedge clk) disable iff (rst)
        !hold_out |=> (div_out != $past(div_out)));

    // R3: hold freezes the output for one edge
    a_r3_stall: assert property (@(posedge clk) disable iff (rst)
        hold_out |=> $stable(div_out));

    // R4: hold is set by select in the low phase
    a_r4_hold_set: assert property (@(posedge clk) disable iff (rst)
        (mod_sel && !div_out) |=> hold_out);

    // R4: hold stays clear otherwise
    a_r4_hold_clear: assert property (@(posedge clk) disable iff (rst)
        (!mod_sel || div_out) |=> !hold_out);

    // R9: hold only while output high, never twice running
    a_r9_hold_high: assert property (@(posedge clk) disable iff (rst)
        hold_out |-> div_out);

    a_r9_hold_single: assert property (@(posedge clk) disable iff (rst)
        hold_out |=> !hold_out);
endmodule

bind dual_mod_prescaler dual_mod_prescaler_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .mod_sel (mod_sel),
    .div_out (div_out),
    .hold_out(hold_out)
);

// File: tb/dual_mod_prescaler_bench.sv
`timescale 1ns/1ps
module dual_mod_prescaler_bench;
    localparam int CLK_NS = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mod_sel = 1'b0;
    logic div_out;
    logic hold_out;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_NS/2.0) clk = ~clk;

    dual_mod_prescaler u_dual_mod_prescaler (
        .clk     (clk),
        .rst     (rst),
        .mod_sel (mod_sel),
        .div_out (div_out),
        .hold_out(hold_out)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic sel);
        rst = 1'b1;
        mod_sel = sel;
        tick();
        rst = 1'b0;
    endtask

    // R1: reset state, also from mid-run
    task automatic t_reset();
        do_reset(1'b0);
        chk("R1", "div_out", div_out, 1'b0);
        chk("R1", "hold_out", hold_out, 1'b0);
        mod_sel = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        do_reset(1'b1);
        chk("R1", "div_out mid-run", div_out, 1'b0);
        chk("R1", "hold_out mid-run", hold_out, 1'b0);
    endtask

    // R5, R2: select low, divide by 2
    task automatic t_div2();
        do_reset(1'b0);
        for (int i = 0; i < 12; i++) begin
            logic prev;
            prev = div_out;
            tick();
            chk("R5", "div_out toggles", div_out, ~prev);
            chk("R2", "hold_out low", hold_out, 1'b0);
        end
    endtask

    // R6, R3, R4: select high, divide by 3
    task automatic t_div3();
        do_reset(1'b1);
        for (int i = 0; i < 15; i++) begin
            tick();
            chk("R6", "div_out pattern", div_out, (i % 3) != 2);
            chk("R4", "hold_out pattern", hold_out, (i % 3) == 0);
        end
    endtask

    // R7: three-edge select pulse swallows one input cycle
    task automatic t_pulse();
        logic exp_d[9] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
        logic exp_h[9] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
        do_reset(1'b0);
        mod_sel = 1'b1;
        for (int i = 0; i < 9; i++) begin
            tick();
            if (i == 2) mod_sel = 1'b0;
            chk("R7", "div_out", div_out, exp_d[i]);
            chk("R7", "hold_out", hold_out, exp_h[i]);
        end
    endtask

    // R8: one-edge select while output high is ignored
    task automatic t_ignore();
        do_reset(1'b0);
        tick();
        chk("R8", "div_out before pulse", div_out, 1'b1);
        mod_sel = 1'b1;
        tick();
        mod_sel = 1'b0;
        chk("R8", "hold_out after pulse", hold_out, 1'b0);
        chk("R8", "div_out after pulse", div_out, 1'b0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R8", "div_out keeps toggling", div_out, (i % 2) == 0);
            chk("R9", "hold_out stays low", hold_out, 1'b0);
        end
    endtask

    bit done = 1'b0;

    initial begin
        #1;
        t_reset();
        t_div2();
        t_div3();
        t_pulse();
        t_ignore();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule